// File: doc/BRIEF.md
# Speculative Load Ordering Tracker

This block keeps one flag per speculative checkpoint for every line of a data cache. When a load that belongs to checkpoint *i* retires speculatively, flag *i* of the line it read is raised. If that line later leaves the cache, by invalidation or by eviction, while flag *i* is still raised, the load may have observed a value that another agent has since changed. Checkpoint *i* is then reported as failed. Loads may therefore retire out of program order without an associative search over outstanding load addresses.

When a checkpoint commits or is abandoned, its flag column is wiped across every line in a single cycle. Because of this, the storage is a plain bit matrix with a flash-clear per column. The failure report is a vector with one bit per checkpoint. It is raised for exactly one cycle, the cycle after the invalidation or eviction that triggered it. Tags, data arrays, coherence and the recovery itself belong to neighbouring blocks.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset `failVec` is zero and no line carries any flag, so an invalidation or eviction of any line produces no failure.
- R2: A retire event (`retireValid`) raises flag `retireCkpt` of line `retireLine`. An eviction of that line then sets bit `retireCkpt` of `failVec` in the cycle after the eviction.
- R3: An invalidation of a flagged line reports its flags on `failVec` in the cycle after the invalidation, in the same way as R2.
- R4: `failVec` holds a report for one cycle only. With no new line event it returns to zero in the next cycle.
- R5: A line carrying flags for several checkpoints fails all of them together in the same `failVec` cycle.
- R6: Bit *i* of `commitMask` clears flag *i* in every line in the same cycle. Later events on those lines report no failure for checkpoint *i*.
- R7: Bit *i* of `abortMask` clears flag *i* in every line, with the same effect as R6.
- R8: When a retire for checkpoint *i* coincides with a commit or abort of checkpoint *i*, the clear wins and the flag stays low.
- R9: An invalidated or evicted line has all its flags cleared after its check, so a new fill starts clean. A retire to that same line in the same cycle is discarded.
- R10: An invalidation and an eviction in the same cycle report the bitwise OR of the flags of both lines.
- R11: A flag hit on a checkpoint that is committed or aborted in the same cycle is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | A speculative load retires this cycle |
| retireLine | input | LINE_W | Line index the load read |
| retireCkpt | input | CKPT_W | Checkpoint the load belongs to (below NUM_CKPT) |
| invalValid | input | 1 | A line is invalidated this cycle |
| invalLine | input | LINE_W | Index of the invalidated line |
| evictValid | input | 1 | A line is evicted this cycle |
| evictLine | input | LINE_W | Index of the evicted line |
| commitMask | input | NUM_CKPT | One bit per checkpoint that commits this cycle |
| abortMask | input | NUM_CKPT | One bit per checkpoint that is abandoned this cycle |
| failVec | output | NUM_CKPT | One-cycle pulse, one bit per checkpoint that must fail |

## Verification
The bench builds the tracker with 8 lines and 4 checkpoints. At that size every line/checkpoint pair can be flagged and then removed by both invalidation and eviction. Every column clear can be checked against a flag pattern that covers all lines. The same-cycle collisions between set, line clear and column clear can each be placed directly. A bit-matrix model in the bench predicts each `failVec` value from the requirements.

// File: rtl/slt_pkg.sv
package slt_pkg;
  // Width of an index able to address n items; never below one bit.
  function automatic int idxWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/slt_ctrl.sv
module slt_ctrl #(
  parameter int NUM_LINES = 512,
  parameter int NUM_CKPT  = 2,
  parameter type strobeT  = logic
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   retireValid,
  input  logic [slt_pkg::idxWidth(NUM_LINES)-1:0] retireLine,
  input  logic [slt_pkg::idxWidth(NUM_CKPT)-1:0]  retireCkpt,
  input  logic                                   invalValid,
  input  logic [slt_pkg::idxWidth(NUM_LINES)-1:0] invalLine,
  input  logic                                   evictValid,
  input  logic [slt_pkg::idxWidth(NUM_LINES)-1:0] evictLine,
  input  logic [NUM_CKPT-1:0]                    commitMask,
  input  logic [NUM_CKPT-1:0]                    abortMask,
  input  logic [NUM_CKPT-1:0]                    rdA,
  input  logic [NUM_CKPT-1:0]                    rdB,
  output strobeT                                 strobes,
  output logic [NUM_CKPT-1:0]                    failVec
);
  logic [NUM_CKPT-1:0] colClr;
  logic [NUM_CKPT-1:0] hitVec;
  logic [NUM_CKPT-1:0] failD;
  logic                ckptOk;

  assign colClr = commitMask | abortMask;
  assign ckptOk = (int'(retireCkpt) < NUM_CKPT);

  always_comb begin
    strobes          = '0;
    strobes.setEn    = retireValid && ckptOk;
    strobes.setLine  = retireLine;
    strobes.setMask  = (retireValid && ckptOk) ? (NUM_CKPT'(1) << retireCkpt) : '0;
    strobes.clrAEn   = invalValid;
    strobes.clrALine = invalLine;
    strobes.clrBEn   = evictValid;
    strobes.clrBLine = evictLine;
    strobes.colClr   = colClr;
  end

  assign hitVec = (invalValid ? rdA : '0) | (evictValid ? rdB : '0);
  assign failD  = hitVec & ~colClr;

  always_ff @(posedge clk) begin
    if (!rst_n) failVec <= '0;
    else        failVec <= failD;
  end

  // R4
  fail_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (failVec != '0) |-> $past(invalValid || evictValid));

  // R11
  no_fail_on_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (failVec & $past(commitMask | abortMask)) == '0);

  // R2
  ckpt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retireValid |-> ckptOk);
endmodule

// File: rtl/slt_bits.sv
module slt_bits #(
  parameter int NUM_LINES = 512,
  parameter int NUM_CKPT  = 2,
  parameter type strobeT  = logic
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobeT              strobes,
  output logic [NUM_CKPT-1:0] rdA,
  output logic [NUM_CKPT-1:0] rdB
);
  localparam int LINE_W = slt_pkg::idxWidth(NUM_LINES);

  logic [NUM_CKPT-1:0] bitsQ [NUM_LINES];
  logic [NUM_CKPT-1:0] bitsD [NUM_LINES];
  logic [NUM_CKPT-1:0] colAny;
  logic                setLineClr;

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      logic lineClr;
      logic setHit;
      lineClr = (strobes.clrAEn && strobes.clrALine == LINE_W'(l)) ||
                (strobes.clrBEn && strobes.clrBLine == LINE_W'(l));
      setHit  = strobes.setEn && strobes.setLine == LINE_W'(l);
      if (lineClr) bitsD[l] = '0;
      else bitsD[l] = (bitsQ[l] | (setHit ? strobes.setMask : '0)) & ~strobes.colClr;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < NUM_LINES; l++) begin
      if (!rst_n) bitsQ[l] <= '0;
      else        bitsQ[l] <= bitsD[l];
    end
  end

  assign rdA = (int'(strobes.clrALine) < NUM_LINES) ? bitsQ[strobes.clrALine] : '0;
  assign rdB = (int'(strobes.clrBLine) < NUM_LINES) ? bitsQ[strobes.clrBLine] : '0;

  assign setLineClr = (strobes.clrAEn && strobes.clrALine == strobes.setLine) ||
                      (strobes.clrBEn && strobes.clrBLine == strobes.setLine);

  for (genvar c = 0; c < NUM_CKPT; c++) begin : g_col
    always_comb begin
      colAny[c] = 1'b0;
      for (int l = 0; l < NUM_LINES; l++) colAny[c] = colAny[c] | bitsQ[l][c];
    end

    // R6
    col_flash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.colClr[c] |=> !colAny[c]);
  end

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.setEn && ((strobes.setMask & strobes.colClr) == '0) && !setLineClr)
      |=> ((bitsQ[$past(strobes.setLine)] & $past(strobes.setMask)) == $past(strobes.setMask)));

  // R9
  line_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrBEn |=> (bitsQ[$past(strobes.clrBLine)] == '0));
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
  parameter int NUM_LINES = 512,
  parameter int NUM_CKPT  = 2,
  localparam int LINE_W   = slt_pkg::idxWidth(NUM_LINES),
  localparam int CKPT_W   = slt_pkg::idxWidth(NUM_CKPT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                retireValid,
  input  logic [LINE_W-1:0]   retireLine,
  input  logic [CKPT_W-1:0]   retireCkpt,
  input  logic                invalValid,
  input  logic [LINE_W-1:0]   invalLine,
  input  logic                evictValid,
  input  logic [LINE_W-1:0]   evictLine,
  input  logic [NUM_CKPT-1:0] commitMask,
  input  logic [NUM_CKPT-1:0] abortMask,
  output logic [NUM_CKPT-1:0] failVec
);
  typedef struct packed {
    logic                setEn;
    logic [LINE_W-1:0]   setLine;
    logic [NUM_CKPT-1:0] setMask;
    logic                clrAEn;
    logic [LINE_W-1:0]   clrALine;
    logic                clrBEn;
    logic [LINE_W-1:0]   clrBLine;
    logic [NUM_CKPT-1:0] colClr;
  } strobeT;

  strobeT              strobes;
  logic [NUM_CKPT-1:0] rdA;
  logic [NUM_CKPT-1:0] rdB;

  slt_ctrl #(.NUM_LINES(NUM_LINES), .NUM_CKPT(NUM_CKPT), .strobeT(strobeT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .retireValid(retireValid), .retireLine(retireLine), .retireCkpt(retireCkpt),
    .invalValid(invalValid), .invalLine(invalLine),
    .evictValid(evictValid), .evictLine(evictLine),
    .commitMask(commitMask), .abortMask(abortMask),
    .rdA(rdA), .rdB(rdB), .strobes(strobes), .failVec(failVec)
  );

  slt_bits #(.NUM_LINES(NUM_LINES), .NUM_CKPT(NUM_CKPT), .strobeT(strobeT)) u_bits (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rdA(rdA), .rdB(rdB)
  );
endmodule

// File: tb/spec_load_tracker_bench.sv
module spec_load_tracker_bench;
  localparam int L = 8;
  localparam int C = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retireValid = 1'b0;
  logic [2:0] retireLine = '0;
  logic [1:0] retireCkpt = '0;
  logic invalValid = 1'b0;
  logic [2:0] invalLine = '0;
  logic evictValid = 1'b0;
  logic [2:0] evictLine = '0;
  logic [C-1:0] commitMask = '0;
  logic [C-1:0] abortMask = '0;
  logic [C-1:0] failVec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [C-1:0] m [L];

  always #10 clk = ~clk;

  spec_load_tracker #(.NUM_LINES(L), .NUM_CKPT(C)) u_spec_load_tracker (
    .clk(clk), .rst_n(rst_n),
    .retireValid(retireValid), .retireLine(retireLine), .retireCkpt(retireCkpt),
    .invalValid(invalValid), .invalLine(invalLine),
    .evictValid(evictValid), .evictLine(evictLine),
    .commitMask(commitMask), .abortMask(abortMask), .failVec(failVec)
  );

  task automatic check(input string tag, input logic [C-1:0] exp);
    checks++;
    if (failVec !== exp) begin
      failures++;
      $display("FAIL %s failVec=%b expected=%b", tag, failVec, exp);
    end
  endtask

  // Drives one cycle of events, advances the model, samples the result one cycle later.
  task automatic cyc(input bit rv, input int rl, input int rc,
                     input bit iv, input int il, input bit ev, input int el,
                     input logic [C-1:0] cm, input logic [C-1:0] am, input string tag);
    logic [C-1:0] exp;
    retireValid = rv; retireLine = 3'(rl); retireCkpt = 2'(rc);
    invalValid = iv; invalLine = 3'(il);
    evictValid = ev; evictLine = 3'(el);
    commitMask = cm; abortMask = am;
    exp = ((iv ? m[il] : '0) | (ev ? m[el] : '0)) & ~(cm | am);
    for (int l = 0; l < L; l++) begin
      if ((iv && il == l) || (ev && el == l)) m[l] = '0;
      else m[l] = (m[l] | ((rv && rl == l) ? (C'(1) << rc) : '0)) & ~(cm | am);
    end
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, '0, '0, tag);
  endtask

  initial begin
    for (int l = 0; l < L; l++) m[l] = '0;
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    // R1: no flags after reset
    for (int l = 0; l < L; l++) cyc(0, 0, 0, 1, l, 0, 0, '0, '0, "R1");

    // R2 / R3 / R4 / R9: every line and checkpoint, both removal kinds
    for (int k = 0; k < 2; k++) begin
      for (int l = 0; l < L; l++) begin
        for (int c = 0; c < C; c++) begin
          cyc(1, l, c, 0, 0, 0, 0, '0, '0, "R2");
          if (k == 0) cyc(0, 0, 0, 0, 0, 1, l, '0, '0, "R2");
          else        cyc(0, 0, 0, 1, l, 0, 0, '0, '0, "R3");
          idle("R4");
          cyc(0, 0, 0, 0, 0, 1, l, '0, '0, "R9");
        end
      end
    end

    // R5: all checkpoints on one line fail together
    for (int c = 0; c < C; c++) cyc(1, 5, c, 0, 0, 0, 0, '0, '0, "R5");
    cyc(0, 0, 0, 1, 5, 0, 0, '0, '0, "R5");

    // R6 / R7: column clears across all lines
    for (int l = 0; l < L; l++) begin
      cyc(1, l, l % C, 0, 0, 0, 0, '0, '0, "R6");
      cyc(1, l, (l + 1) % C, 0, 0, 0, 0, '0, '0, "R6");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 4'b0010, '0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, '0, 4'b0100, "R7");
    for (int l = 0; l < L; l++) cyc(0, 0, 0, 1, l, 0, 0, '0, '0, "R6_R7");

    // R8: set and clear of same checkpoint in one cycle
    cyc(1, 3, 2, 0, 0, 0, 0, 4'b0100, '0, "R8");
    cyc(1, 2, 1, 0, 0, 0, 0, '0, 4'b0010, "R8");
    cyc(0, 0, 0, 1, 2, 1, 3, '0, '0, "R8");

    // R9: retire into a line being evicted is discarded
    cyc(1, 6, 1, 0, 0, 1, 6, '0, '0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 6, '0, '0, "R9");

    // R10: invalidate and evict together
    cyc(1, 1, 0, 0, 0, 0, 0, '0, '0, "R10");
    cyc(1, 2, 3, 0, 0, 0, 0, '0, '0, "R10");
    cyc(0, 0, 0, 1, 1, 1, 2, '0, '0, "R10");

    // R11: hit suppressed by same-cycle commit/abort
    cyc(1, 4, 2, 0, 0, 0, 0, '0, '0, "R11");
    cyc(1, 4, 0, 0, 0, 0, 0, '0, '0, "R11");
    cyc(0, 0, 0, 0, 0, 1, 4, 4'b0100, '0, "R11");
    cyc(1, 7, 3, 0, 0, 0, 0, '0, '0, "R11");
    cyc(0, 0, 0, 1, 7, 0, 0, '0, 4'b1000, "R11");
    idle("R4");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule